// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits between the external interrupt inputs of a processor core and its instruction sequencer. It watches a level-sensitive maskable request and an edge-sensitive non-maskable request, and it reads the core's interrupt-enable flag. It makes its decisions only at instruction boundaries that the core reports. At such a boundary it either reports that the non-maskable interrupt is taken, or it starts a two-pulse acknowledge sequence on the active-low acknowledge output for the maskable request.

The block also gates the wait-for-test instruction. While the core reports that this instruction is executing, a stall is raised for as long as the sampled test input is high. If the test input is already low, the instruction costs nothing. A stalled wait is treated as an interruptible point: a request that would be accepted at a boundary is accepted there as well.

Vector fetch, stack handling and execution stay in the core. The block supplies only the take indications, the acknowledge pulses, a vector-valid strobe and the stall.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A synchronous active-high reset returns `inta_n` to 1 and `take_nmi`, `take_mask` and `vec_strobe` to 0. It discards any non-maskable edge seen before or during reset. A level that is held high through reset does not count as an edge.
- R2: A rising edge on `nmi_req`, however short, is latched. The next decision point then raises `take_nmi` for exactly one cycle, in the cycle after that point, whatever the value of `ie_flag`.
- R3: The maskable request is accepted only if `intr_req` and `ie_flag` are both 1 at the decision point itself. It is never latched.
- R4: If a latched NMI and an acceptable maskable request meet at the same decision point, only `take_nmi` is raised. The maskable request can be taken at a later point if it is still present.
- R5: An accepted maskable request raises `take_mask` for one cycle. In the cycle after the decision point, `inta_n` goes low for PULSE_CYCLES cycles, then high for GAP_CYCLES cycles, then low again for PULSE_CYCLES cycles.
- R6: `vec_strobe` is 1 only in the last cycle of the second low pulse on `inta_n`.
- R7: A decision point is a cycle in which `insn_boundary` is 1 or the stall is active, and the acknowledge sequence is idle. No take indication is raised without one, and boundaries that arrive during an acknowledge sequence are ignored.
- R8: `stall` equals `wait_busy` ANDed with the value of `test_n` sampled at the previous clock edge. When `test_n` is already low, the wait instruction does not stall.
- R9: A cycle in which the wait instruction is stalled is a decision point, so a latched NMI is taken during the stall without any `insn_boundary`.
- R10: A latched NMI is cleared by the decision that takes it. One edge produces exactly one `take_nmi`, and an `nmi_req` that stays high does not trigger again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intr_req | input | 1 | Maskable request, level sensitive |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| insn_boundary | input | 1 | Current instruction has finished |
| wait_busy | input | 1 | Wait-for-test instruction is executing |
| test_n | input | 1 | Test input, active low |
| inta_n | output | 1 | Acknowledge pulses, active low |
| vec_strobe | output | 1 | Vector valid, last cycle of the second pulse |
| take_nmi | output | 1 | One-cycle non-maskable take indication |
| take_mask | output | 1 | One-cycle maskable take indication |
| stall | output | 1 | Hold the core in the wait instruction |

## Verification
The hardest case to reach is a decision point that does not come from a boundary. This happens when the latched NMI is taken while the wait instruction is stalled, and it requires the test input to be sampled high before the NMI edge arrives. Directed sequences build that situation, and they also build an NMI edge that meets an enabled maskable request at the same boundary. Further directed sequences place boundaries inside a running acknowledge sequence. A long random phase then mixes sparse boundaries, NMI toggles, wait windows and occasional resets, and every output is compared in every cycle with a model written from the requirements.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_state_e;

    typedef struct packed {
        logic nmi;
        logic mask;
    } take_t;

    // Priority choice at one decision point: latched NMI first, then an enabled level request.
    function automatic take_t pick_take(logic decide, logic nmi_pend, logic intr, logic ie);
        take_t t;
        t.nmi  = decide & nmi_pend;
        t.mask = decide & ~nmi_pend & intr & ie;
        return t;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irq_nmi_catch.sv
module irq_nmi_catch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic take_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise   = nmi_i & ~prev_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= nmi_i;   // a level held through reset is not an edge
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_i;
            pend_q <= rise | (pend_q & ~take_i);
        end
    end

    assert_nmi_edge_latched_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_i) |=> pend_o);

    assert_nmi_cleared_on_take_R10: assert property (@(posedge clk) disable iff (rst)
        (take_i && !$rose(nmi_i)) |=> !pend_o);

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 2,
    parameter int unsigned GAP_CYCLES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic inta_n_o,
    output logic strobe_o
);
    localparam int unsigned CW = $clog2(max2(PULSE_CYCLES, GAP_CYCLES) + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYCLES - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYCLES - 1);

    ack_state_e    st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ACK_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ACK_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) st_q <= ACK_FIRST;
                end
                ACK_FIRST: begin
                    if (cnt_q == PULSE_LAST) begin
                        st_q  <= ACK_GAP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ACK_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        st_q  <= ACK_SECOND;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ACK_SECOND: begin
                    if (cnt_q == PULSE_LAST) begin
                        st_q  <= ACK_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= ACK_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign busy_o   = (st_q != ACK_IDLE);
    assign inta_n_o = ~((st_q == ACK_FIRST) | (st_q == ACK_SECOND));
    assign strobe_o = (st_q == ACK_SECOND) & (cnt_q == PULSE_LAST);

    assert_start_drops_inta_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> !inta_n_o);

    assert_strobe_inside_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (!inta_n_o && busy_o));

    assert_strobe_ends_seq_R6: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> (inta_n_o && !strobe_o));

endmodule

// File: rtl/irq_wait_gate.sv
module irq_wait_gate (
    input  logic clk,
    input  logic wait_i,
    input  logic test_n_i,
    output logic stall_o
);
    // Plain input sample; no reset, so it already tracks the pin while reset is held.
    logic test_q;

    always_ff @(posedge clk) begin
        test_q <= test_n_i;
    end

    assign stall_o = wait_i & test_q;

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_seq_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 2,
    parameter int unsigned GAP_CYCLES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic intr_req,
    input  logic nmi_req,
    input  logic ie_flag,
    input  logic insn_boundary,
    input  logic wait_busy,
    input  logic test_n,
    output logic inta_n,
    output logic vec_strobe,
    output logic take_nmi,
    output logic take_mask,
    output logic stall
);
    logic  nmi_pend;
    logic  ack_busy;
    logic  decide;
    take_t take_now;
    take_t take_q;

    irq_nmi_catch u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_i  (nmi_req),
        .take_i (take_now.nmi),
        .pend_o (nmi_pend)
    );

    irq_wait_gate u_wait (
        .clk      (clk),
        .wait_i   (wait_busy),
        .test_n_i (test_n),
        .stall_o  (stall)
    );

    irq_ack_seq #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .GAP_CYCLES   (GAP_CYCLES)
    ) u_ack (
        .clk      (clk),
        .rst      (rst),
        .start_i  (take_now.mask),
        .busy_o   (ack_busy),
        .inta_n_o (inta_n),
        .strobe_o (vec_strobe)
    );

    assign decide   = ~ack_busy & (insn_boundary | stall);
    assign take_now = pick_take(decide, nmi_pend, intr_req, ie_flag);

    always_ff @(posedge clk) begin
        if (rst) take_q <= '0;
        else     take_q <= take_now;
    end

    assign take_nmi  = take_q.nmi;
    assign take_mask = take_q.mask;

    assert_takes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(take_nmi && take_mask));

    assert_mask_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        take_mask |-> $past(ie_flag && intr_req));

    assert_busy_ignores_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_busy && insn_boundary) |=> (!take_nmi && !take_mask));

    assert_take_needs_point_R7: assert property (@(posedge clk) disable iff (rst)
        (!insn_boundary && !stall) |=> (!take_nmi && !take_mask));

    assert_stall_needs_wait_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> wait_busy);

    assert_test_low_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (wait_busy && $past(!test_n)) |-> !stall);

endmodule

// File: tb/irq_ack_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb_top;
    localparam int unsigned PULSE = 2;
    localparam int unsigned GAP   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic intr_req = 0, nmi_req = 0, ie_flag = 0, insn_boundary = 0, wait_busy = 0, test_n = 1;
    logic inta_n, vec_strobe, take_nmi, take_mask, stall;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    irq_ack_ctrl #(.PULSE_CYCLES(PULSE), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst(rst), .intr_req(intr_req), .nmi_req(nmi_req), .ie_flag(ie_flag),
        .insn_boundary(insn_boundary), .wait_busy(wait_busy), .test_n(test_n),
        .inta_n(inta_n), .vec_strobe(vec_strobe), .take_nmi(take_nmi),
        .take_mask(take_mask), .stall(stall)
    );

    // Reference model built from the requirements
    int   m_phase = 0;   // 0 idle, 1 first pulse, 2 gap, 3 second pulse
    int   m_cnt = 0;
    logic m_pend = 0, m_prev = 0, m_testq = 1, m_tn = 0, m_tm = 0;

    always @(posedge clk) begin
        logic rise, point, tn, tm;
        cycles++;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_pend = 0; m_prev = nmi_req; m_tn = 0; m_tm = 0;
        end else begin
            rise  = nmi_req & ~m_prev;
            point = (m_phase == 0) && (insn_boundary || (wait_busy && m_testq));
            tn    = point && m_pend;
            tm    = point && !m_pend && intr_req && ie_flag;
            m_pend = rise | (m_pend & ~tn);
            m_prev = nmi_req;
            m_tn = tn; m_tm = tm;
            case (m_phase)
                0: if (tm) begin m_phase = 1; m_cnt = 0; end
                1: if (m_cnt == PULSE-1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
                2: if (m_cnt == GAP-1)   begin m_phase = 3; m_cnt = 0; end else m_cnt++;
                default: if (m_cnt == PULSE-1) begin m_phase = 0; m_cnt = 0; end else m_cnt++;
            endcase
        end
        m_testq = test_n;
    end

    function automatic logic exp_inta_n();
        return !(m_phase == 1 || m_phase == 3);
    endfunction
    function automatic logic exp_strobe();
        return (m_phase == 3) && (m_cnt == PULSE-1);
    endfunction

    task automatic cmp(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp(inta_n,     exp_inta_n(),          "R5", "inta_n");
        cmp(vec_strobe, exp_strobe(),          "R6", "vec_strobe");
        cmp(take_nmi,   m_tn,                  "R2", "take_nmi");
        cmp(take_mask,  m_tm,                  "R3", "take_mask");
        cmp(stall,      wait_busy && m_testq,  "R8", "stall");
    endtask

    initial begin
        int watch = 0;
        forever begin
            @(posedge clk);
            watch++;
            if (watch > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: an NMI edge during reset is dropped
        rst = 1; tick(); tick(); tick();
        nmi_req = 1; tick(); nmi_req = 0; tick();
        rst = 0; tick();
        cmp(inta_n, 1'b1, "R1", "inta_n after reset");
        cmp(take_nmi, 1'b0, "R1", "take_nmi after reset");
        cmp(take_mask, 1'b0, "R1", "take_mask after reset");
        cmp(vec_strobe, 1'b0, "R1", "vec_strobe after reset");
        insn_boundary = 1; tick(); insn_boundary = 0;
        cmp(take_nmi, 1'b0, "R1", "no NMI from edge in reset");

        // R2 / R7: short pulse latched, waits for a boundary, ie ignored
        ie_flag = 0; nmi_req = 1; tick(); nmi_req = 0; tick(); tick();
        cmp(take_nmi, 1'b0, "R7", "no take without boundary");
        insn_boundary = 1; tick(); insn_boundary = 0;
        cmp(take_nmi, 1'b1, "R2", "latched NMI taken with ie=0");
        tick();
        cmp(take_nmi, 1'b0, "R2", "take_nmi one cycle");

        // R4: NMI beats INTR, INTR taken at the next boundary
        ie_flag = 1; intr_req = 1; nmi_req = 1; tick(); nmi_req = 0;
        insn_boundary = 1; tick();
        cmp(take_nmi, 1'b1, "R4", "NMI wins");
        cmp(take_mask, 1'b0, "R4", "INTR held back");
        tick();
        cmp(take_mask, 1'b1, "R4", "INTR taken at next boundary");
        cmp(inta_n, 1'b0, "R5", "first pulse starts");
        // R7: boundary during the sequence is ignored
        tick();
        cmp(take_mask, 1'b0, "R7", "boundary ignored while busy");
        insn_boundary = 0; intr_req = 0;
        for (int i = 0; i < 8; i++) tick();

        // R10: held NMI fires once
        nmi_req = 1; tick(); insn_boundary = 1; tick();
        cmp(take_nmi, 1'b1, "R10", "held NMI first take");
        tick();
        cmp(take_nmi, 1'b0, "R10", "held NMI no retrigger");
        insn_boundary = 0; nmi_req = 0; tick();

        // R3: mask or missing level blocks the request
        ie_flag = 0; intr_req = 1; insn_boundary = 1; tick();
        cmp(take_mask, 1'b0, "R3", "ie=0 blocks");
        ie_flag = 1; intr_req = 0; tick();
        cmp(take_mask, 1'b0, "R3", "no level, no take");
        insn_boundary = 0; tick();

        // R8 / R9: wait instruction
        test_n = 0; wait_busy = 1; tick();
        cmp(stall, 1'b0, "R8", "test low: no stall");
        test_n = 1; tick();
        cmp(stall, 1'b1, "R8", "test high: stall");
        nmi_req = 1; tick(); nmi_req = 0; tick();
        cmp(take_nmi, 1'b1, "R9", "NMI taken during stall");
        wait_busy = 0; tick();

        // Random phase compared against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            insn_boundary = ($urandom % 4) == 0;
            intr_req      = ($urandom % 3) == 0;
            ie_flag       = ($urandom % 2) == 0;
            if (($urandom % 8) == 0) nmi_req = ~nmi_req;
            if (($urandom % 16) == 0) wait_busy = ~wait_busy;
            test_n        = ($urandom % 2) == 0;
            rst           = ($urandom % 600) == 0;
            tick();
            if (rst) begin
                for (int k = 0; k < 3; k++) tick();
                rst = 0;
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule